// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a set of interrupt inputs (32 by default) and turns them into two active-low requests for a processor: a fast request line driven only by source 0, and a normal request line shared by every other source. Each source has a mode word that selects a priority and a trigger type. The trigger type is a level or an edge, in either polarity. Each source also has a vector word that software fills in. All of this storage, plus the status, mask, pending, command and spurious-vector registers, sits behind a simple single-cycle register bus. Read data returns one cycle after the request.

A handler reads the IRQ vector register and gets the vector of the best pending, enabled source. That read also acknowledges the source: an edge-triggered source loses its pending bit, and the source's number and priority go onto a nesting stack. The normal request line is then held off until a strictly higher priority arrives or an end-of-interrupt write pops the stack. A vector read that finds nothing eligible returns the programmable spurious vector.

Top module: `vic_ctrl`

## Requirements
- R1: After reset both request outputs are high, the mask reads 0, the current-source register reads 0 and the core-status register reads 3.
- R2: A mode word reads back with the trigger type in bits [6:5] and the priority in bits [2:0], with every other bit 0. A vector word reads back as the low VEC_W bits written.
- R3: Trigger type 00 makes a source pending while its input is low, and 10 while it is high. Type 01 latches pending on a falling edge and 11 on a rising edge, and the latch holds after the input returns to its inactive level.
- R4: Each 1 bit written to the enable command (address 0x88) sets that mask bit, and each 1 bit written to the disable command (0x89) clears it. Bits written as 0 leave the mask unchanged. The mask reads at 0x84.
- R5: The set command (0x8B) and clear command (0x8A) set and clear the pending latch of edge-triggered sources. On a level-triggered source the set command has no effect. Pending reads at 0x83.
- R6: nfiq_o is low exactly when source 0 is pending and enabled. A read of 0x81 returns source 0's vector.
- R7: Among sources 1 and up that are pending and enabled, the highest priority wins, and on a tie the lower source number wins. A read of 0x80 returns the winner's vector.
- R8: An acknowledging read of 0x80 clears the winner's pending bit when it is edge-triggered and leaves a level source pending. It also makes the current-source register (0x82) report the winner's number.
- R9: nirq_o is low only when some enabled source 1 and up is pending with a priority strictly above the top of the nesting stack, or the stack is empty.
- R10: A write to the end-of-interrupt command (0x8C) pops the stack. The current-source register returns to the previous entry, or to 0 when the stack is empty, and nirq_o is re-evaluated. On an empty stack the write has no effect.
- R11: A read of 0x80 when R9 finds no eligible request returns the spurious vector (read and written at 0x86) and pushes nothing.
- R12: Core-status (0x85) bit 0 equals nfiq_o and bit 1 equals nirq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Raw interrupt inputs, synchronised inside |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| nirq_o | output | 1 | Normal interrupt request, active low |
| nfiq_o | output | 1 | Fast interrupt request (source 0), active low |

## Verification
The bench builds the controller with 8 sources, all 8 priority levels and 16-bit vectors. At that size every source can be driven through all four trigger types. Every pair of sources 1 to 7 is tried against every pair of priority values, so the tie rule and the winner rule are checked in full. A nesting scenario checks equal-priority blocking, the spurious fallback and stack unwinding.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // trigger encoding: bit 0 selects edge, bit 1 selects high/rising polarity
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_HIGH = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;

  localparam int ADDR_W = 8;

  localparam logic [7:0] A_IRQ_VEC = 8'h80;
  localparam logic [7:0] A_FIQ_VEC = 8'h81;
  localparam logic [7:0] A_CUR_ID  = 8'h82;
  localparam logic [7:0] A_PENDING = 8'h83;
  localparam logic [7:0] A_MASK    = 8'h84;
  localparam logic [7:0] A_CORE    = 8'h85;
  localparam logic [7:0] A_SPUR    = 8'h86;
  localparam logic [7:0] A_EN_CMD  = 8'h88;
  localparam logic [7:0] A_DIS_CMD = 8'h89;
  localparam logic [7:0] A_CLR_CMD = 8'h8A;
  localparam logic [7:0] A_SET_CMD = 8'h8B;
  localparam logic [7:0] A_EOI_CMD = 8'h8C;
  // mode words live at 0x00+n, vector words at 0x40+n
  localparam logic [1:0] REG_MODE = 2'b00;
  localparam logic [1:0] REG_VEC  = 2'b01;
endpackage

// File: rtl/vic_src_cond.sv
module vic_src_cond
  import vic_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  raw_i,
  input  trig_e trig_i,
  input  logic  set_i,
  input  logic  clr_i,
  output logic  pend_o
);
  logic s1_q, s2_q, s3_q, latch_q, latch_d;
  logic is_edge, hi_pol, edge_hit, level_on;

  assign is_edge  = trig_i[0];
  assign hi_pol   = trig_i[1];
  assign edge_hit = hi_pol ? (s2_q & ~s3_q) : (~s2_q & s3_q);
  assign level_on = hi_pol ? s2_q : ~s2_q;

  // a fresh edge wins over a clear in the same cycle
  always_comb begin
    if (is_edge) latch_d = (latch_q & ~clr_i) | set_i | edge_hit;
    else         latch_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      s3_q    <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      s1_q    <= raw_i;
      s2_q    <= s1_q;
      s3_q    <= s2_q;
      latch_q <= latch_d;
    end
  end

  assign pend_o = is_edge ? latch_q : level_on;
endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int FIRST  = 1,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]        cand_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  output logic                   found_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic [PRIO_W-1:0]      prio_o
);
  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (i >= FIRST && cand_i[i] &&
          (!found_o || prio_i[i*PRIO_W +: PRIO_W] > prio_o)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/vic_stack.sv
module vic_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     din_i,
  output logic [W-1:0]     top_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] wr_ptr, top_ptr;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign wr_ptr  = PTR_W'(cnt_q);
  assign top_ptr = PTR_W'(cnt_q - 1'b1);
  assign top_o   = empty_o ? '0 : mem[top_ptr];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (push_i && !full_o) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst)                       cnt_q <= '0;
    else if (push_i && !full_o)    cnt_q <= cnt_q + 1'b1;
    else if (pop_i && !empty_o)    cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int DATA_W = 32,
  parameter int VEC_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              nirq_o,
  output logic              nfiq_o
);
  localparam int IDX_W = $clog2(NSRC);
  localparam int DEPTH = 2 ** PRIO_W;
  localparam int ENT_W = IDX_W + PRIO_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  // ---------------- bus decode ----------------
  logic wr, rd, in_range, mode_acc, vec_acc;
  logic is_ivr, is_fvr;
  logic [IDX_W-1:0] src_sel;

  assign wr       = bus_en & bus_we;
  assign rd       = bus_en & ~bus_we;
  assign in_range = int'(bus_addr[5:0]) < NSRC;
  assign mode_acc = (bus_addr[7:6] == REG_MODE) && in_range;
  assign vec_acc  = (bus_addr[7:6] == REG_VEC) && in_range;
  assign is_ivr   = rd && (bus_addr == A_IRQ_VEC);
  assign is_fvr   = (bus_addr == A_FIQ_VEC);
  assign src_sel  = bus_addr[IDX_W-1:0];

  // ---------------- per-source mode storage ----------------
  logic [PRIO_W-1:0] prio_q [NSRC];
  trig_e             trig_q [NSRC];
  logic [NSRC*PRIO_W-1:0] prio_flat;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSRC; i++) begin
        prio_q[i] <= '0;
        trig_q[i] <= TRIG_LOW;
      end
    end else if (wr && mode_acc) begin
      prio_q[src_sel] <= bus_wdata[PRIO_W-1:0];
      trig_q[src_sel] <= trig_e'(bus_wdata[6:5]);
    end
  end

  always_comb begin
    for (int i = 0; i < NSRC; i++) prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
  end

  // ---------------- mask and commands ----------------
  logic [NSRC-1:0] mask_q, set_vec, clr_vec, ack_vec, pend;
  logic [VEC_W-1:0] spur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      spur_q <= '0;
    end else if (wr) begin
      if (bus_addr == A_EN_CMD)  mask_q <= mask_q | bus_wdata[NSRC-1:0];
      if (bus_addr == A_DIS_CMD) mask_q <= mask_q & ~bus_wdata[NSRC-1:0];
      if (bus_addr == A_SPUR)    spur_q <= bus_wdata[VEC_W-1:0];
    end
  end

  assign set_vec = (wr && bus_addr == A_SET_CMD) ? bus_wdata[NSRC-1:0] : '0;

  // ---------------- source conditioning ----------------
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    vic_src_cond u_cond (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (src_i[g]),
      .trig_i (trig_q[g]),
      .set_i  (set_vec[g]),
      .clr_i  (clr_vec[g]),
      .pend_o (pend[g])
    );
  end

  // ---------------- arbitration ----------------
  logic              found;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_prio;

  vic_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W), .FIRST(1)) u_arb (
    .cand_i  (pend & mask_q),
    .prio_i  (prio_flat),
    .found_o (found),
    .idx_o   (win_idx),
    .prio_o  (win_prio)
  );

  // ---------------- nesting stack ----------------
  logic              stk_push, stk_pop, stk_empty, stk_full;
  logic [ENT_W-1:0]  stk_top;
  logic [CNT_W-1:0]  stk_cnt;
  logic [PRIO_W-1:0] top_prio;
  logic [IDX_W-1:0]  cur_id;
  logic              irq_req;

  assign top_prio = stk_top[PRIO_W-1:0];
  assign cur_id   = stk_top[ENT_W-1:PRIO_W];
  assign irq_req  = found && (stk_empty || win_prio > top_prio);
  assign stk_push = is_ivr && irq_req;
  assign stk_pop  = wr && (bus_addr == A_EOI_CMD);
  assign ack_vec  = stk_push ? (NSRC'(1) << win_idx) : '0;
  assign clr_vec  = ((wr && bus_addr == A_CLR_CMD) ? bus_wdata[NSRC-1:0] : '0) | ack_vec;

  vic_stack #(.DEPTH(DEPTH), .W(ENT_W)) u_stack (
    .clk     (clk),
    .rst     (rst),
    .push_i  (stk_push),
    .pop_i   (stk_pop),
    .din_i   ({win_idx, win_prio}),
    .top_o   (stk_top),
    .empty_o (stk_empty),
    .full_o  (stk_full),
    .cnt_o   (stk_cnt)
  );

  // ---------------- registered request lines ----------------
  logic nirq_q, nfiq_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      nirq_q <= 1'b1;
      nfiq_q <= 1'b1;
    end else begin
      nirq_q <= ~irq_req;
      nfiq_q <= ~(pend[0] & mask_q[0]);
    end
  end
  assign nirq_o = nirq_q;
  assign nfiq_o = nfiq_q;

  // ---------------- vector table (one write, one read port) ----------------
  logic [VEC_W-1:0] vec_mem [NSRC];
  logic [VEC_W-1:0] vec_q;
  logic [IDX_W-1:0] vec_ridx;

  always_comb begin
    if (is_ivr)      vec_ridx = win_idx;
    else if (is_fvr) vec_ridx = '0;
    else             vec_ridx = src_sel;
  end

  always_ff @(posedge clk) begin
    if (wr && vec_acc) vec_mem[src_sel] <= bus_wdata[VEC_W-1:0];
  end

  always_ff @(posedge clk) begin
    vec_q <= vec_mem[vec_ridx];
  end

  // ---------------- read data path ----------------
  logic              use_vec_q, use_vec_d;
  logic [DATA_W-1:0] word_q, word_d;

  assign use_vec_d = vec_acc || is_fvr || (is_ivr && irq_req);

  always_comb begin
    word_d = '0;
    if (mode_acc) begin
      word_d[6:5]        = trig_q[src_sel];
      word_d[PRIO_W-1:0] = prio_q[src_sel];
    end else begin
      case (bus_addr)
        A_IRQ_VEC, A_SPUR: word_d = DATA_W'(spur_q);
        A_CUR_ID:          word_d = DATA_W'(cur_id);
        A_PENDING:         word_d = DATA_W'(pend);
        A_MASK:            word_d = DATA_W'(mask_q);
        A_CORE:            word_d = DATA_W'({nirq_q, nfiq_q});
        default:           word_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      use_vec_q <= 1'b0;
      word_q    <= '0;
    end else if (rd) begin
      use_vec_q <= use_vec_d;
      word_q    <= word_d;
    end
  end

  assign bus_rdata = use_vec_q ? DATA_W'(vec_q) : word_q;
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  localparam int IDX_W = $clog2(NSRC),
  localparam int CNT_W = $clog2((2 ** PRIO_W) + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              nirq_o,
  input logic              nfiq_o,
  input logic [NSRC-1:0]   pend,
  input logic [NSRC-1:0]   mask_q,
  input logic              stk_push,
  input logic              stk_pop,
  input logic              stk_full,
  input logic              stk_empty,
  input logic [CNT_W-1:0]  stk_cnt,
  input logic [PRIO_W-1:0] win_prio,
  input logic [PRIO_W-1:0] top_prio,
  input logic [IDX_W-1:0]  win_idx,
  input logic [IDX_W-1:0]  cur_id
);
  AST_FIQ_FOLLOWS_SRC0: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (nfiq_o == !($past(pend[0]) && $past(mask_q[0])))); // R6

  AST_MASKED_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (mask_q[NSRC-1:1] == '0) |=> nirq_o); // R9

  AST_STACK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    stk_push |-> !stk_full); // R8

  AST_NEST_RISES: assert property (@(posedge clk) disable iff (rst)
    (stk_push && !stk_empty) |-> (win_prio > top_prio)); // R9

  AST_ACK_SETS_ID: assert property (@(posedge clk) disable iff (rst)
    stk_push |=> (cur_id == $past(win_idx))); // R8

  AST_EOI_POPS: assert property (@(posedge clk) disable iff (rst)
    (stk_pop && stk_cnt != '0) |=> (stk_cnt == CNT_W'($past(stk_cnt) - 1'b1))); // R10
endmodule

bind vic_ctrl vic_ctrl_chk #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .nirq_o    (nirq_o),
  .nfiq_o    (nfiq_o),
  .pend      (pend),
  .mask_q    (mask_q),
  .stk_push  (stk_push),
  .stk_pop   (stk_pop),
  .stk_full  (stk_full),
  .stk_empty (stk_empty),
  .stk_cnt   (stk_cnt),
  .win_prio  (win_prio),
  .top_prio  (top_prio),
  .win_idx   (win_idx),
  .cur_id    (cur_id)
);

// File: tb/vic_ctrl_test.sv
module vic_ctrl_test;
  import vic_pkg::*;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] src = '0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        nirq, nfiq;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  vic_ctrl #(.NSRC(N), .PRIO_W(3), .DATA_W(32), .VEC_W(16)) uut (
    .clk(clk), .rst(rst), .src_i(src), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nirq_o(nirq), .nfiq_o(nfiq)
  );

  function automatic logic [31:0] vexp(input int i);
    return 32'(16'hA000 + 16'(i * 273));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic br(input logic [7:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  m;
    settle(4);
    rst = 1'b0;
    settle(1);

    // R1 and R12 reset state
    chk("R1 nirq", {31'b0, nirq}, 32'd1);
    chk("R1 nfiq", {31'b0, nfiq}, 32'd1);
    br(A_CORE, d);   chk("R1 R12 core status", d, 32'd3);
    br(A_MASK, d);   chk("R1 mask", d, 32'd0);
    br(A_CUR_ID, d); chk("R1 current id", d, 32'd0);

    // R2 mode and vector readback
    for (int i = 0; i < N; i++) begin
      bw(8'(i), 32'hFFFF_FF98 | 32'((i % 4) << 5) | 32'(7 - i));
      bw(8'h40 + 8'(i), 32'hDEAD_0000 | vexp(i));
    end
    for (int i = 0; i < N; i++) begin
      br(8'(i), d);        chk("R2 mode word", d, 32'((i % 4) << 5) | 32'(7 - i));
      br(8'h40 + 8'(i), d); chk("R2 vector word", d, vexp(i));
    end
    for (int i = 0; i < N; i++) bw(8'(i), 32'h60);

    // R3 and R5: every trigger type on every shared source
    for (int i = 1; i < N; i++) begin
      for (int t = 0; t < 4; t++) begin
        logic inact;
        logic is_edge;
        inact   = (t < 2);
        is_edge = t[0];
        src[i] = inact;
        settle(6);
        bw(8'(i), 32'(t << 5));
        bw(A_CLR_CMD, 32'(1) << i);
        br(A_PENDING, d); chk("R3 idle pending", 32'(d[i]), 32'd0);
        src[i] = ~inact;
        settle(6);
        br(A_PENDING, d); chk("R3 active pending", 32'(d[i]), 32'd1);
        src[i] = inact;
        settle(6);
        br(A_PENDING, d); chk("R3 after return", 32'(d[i]), is_edge ? 32'd1 : 32'd0);
        if (is_edge) begin
          bw(A_CLR_CMD, 32'(1) << i);
          br(A_PENDING, d); chk("R5 clear edge", 32'(d[i]), 32'd0);
          bw(A_SET_CMD, 32'(1) << i);
          br(A_PENDING, d); chk("R5 set edge", 32'(d[i]), 32'd1);
          bw(A_CLR_CMD, 32'(1) << i);
          br(A_PENDING, d); chk("R5 clear after set", 32'(d[i]), 32'd0);
        end else begin
          bw(A_SET_CMD, 32'(1) << i);
          br(A_PENDING, d); chk("R5 set ignored on level", 32'(d[i]), 32'd0);
        end
      end
      bw(8'(i), 32'h60);
    end

    // R4 mask commands
    m = '0;
    bw(A_EN_CMD, 32'hA5);  m = m | 8'hA5; br(A_MASK, d); chk("R4 enable", d, 32'(m));
    bw(A_DIS_CMD, 32'h21); m = m & ~8'h21; br(A_MASK, d); chk("R4 disable", d, 32'(m));
    bw(A_EN_CMD, 32'h0F);  m = m | 8'h0F; br(A_MASK, d); chk("R4 enable more", d, 32'(m));
    bw(A_DIS_CMD, 32'hF0); m = m & ~8'hF0; br(A_MASK, d); chk("R4 disable high", d, 32'(m));
    bw(A_EN_CMD, 32'h00);  br(A_MASK, d); chk("R4 zero enable", d, 32'(m));
    bw(A_DIS_CMD, 32'h00); br(A_MASK, d); chk("R4 zero disable", d, 32'(m));
    bw(A_DIS_CMD, 32'hFF); br(A_MASK, d); chk("R4 disable all", d, 32'd0);

    // R6 fast request from source 0
    bw(A_EN_CMD, 32'h1);
    settle(3); chk("R6 nfiq idle", {31'b0, nfiq}, 32'd1);
    src[0] = 1'b1;
    settle(6); chk("R6 nfiq asserted", {31'b0, nfiq}, 32'd0);
    br(A_CORE, d);    chk("R12 core status fiq", d, 32'd2);
    br(A_FIQ_VEC, d); chk("R6 fiq vector", d, vexp(0));
    bw(A_CLR_CMD, 32'h1);
    settle(3); chk("R6 nfiq released", {31'b0, nfiq}, 32'd1);
    src[0] = 1'b0;
    bw(A_DIS_CMD, 32'h1);

    // R7 R8 R9: every pair of shared sources at every priority pair
    for (int a = 1; a < N; a++) begin
      for (int b = a + 1; b < N; b++) begin
        for (int pa = 0; pa < 8; pa++) begin
          for (int pb = 0; pb < 8; pb++) begin
            int win;
            logic [31:0] both;
            both = (32'(1) << a) | (32'(1) << b);
            win  = (pb > pa) ? b : a;
            bw(8'(a), 32'h60 | 32'(pa));
            bw(8'(b), 32'h60 | 32'(pb));
            bw(A_SET_CMD, both);
            bw(A_EN_CMD, both);
            settle(3); chk("R9 request raised", {31'b0, nirq}, 32'd0);
            br(A_IRQ_VEC, d); chk("R7 winner vector", d, vexp(win));
            br(A_CUR_ID, d);  chk("R8 current id", d, 32'(win));
            br(A_PENDING, d); chk("R8 edge ack clears", d, both & ~(32'(1) << win));
            bw(A_EOI_CMD, 32'h0);
            bw(A_CLR_CMD, both);
            bw(A_DIS_CMD, both);
          end
        end
      end
    end
    settle(3);

    // R9 R10 R11 nesting
    bw(A_SPUR, 32'h0000_5A5A);
    br(A_SPUR, d); chk("R11 spurious readback", d, 32'h5A5A);
    br(A_IRQ_VEC, d); chk("R11 spurious on empty", d, 32'h5A5A);
    br(A_CUR_ID, d);  chk("R11 no push", d, 32'd0);
    bw(8'd2, 32'h63);
    bw(8'd5, 32'h66);
    bw(8'd1, 32'h63);
    bw(A_EN_CMD, 32'h26);
    bw(A_SET_CMD, 32'h04);
    settle(3); chk("R9 first request", {31'b0, nirq}, 32'd0);
    br(A_IRQ_VEC, d); chk("R7 vector src2", d, vexp(2));
    settle(2); chk("R9 held by stack", {31'b0, nirq}, 32'd1);
    br(A_CUR_ID, d); chk("R8 id 2", d, 32'd2);
    bw(A_SET_CMD, 32'h20);
    settle(3); chk("R9 higher preempts", {31'b0, nirq}, 32'd0);
    br(A_IRQ_VEC, d); chk("R7 vector src5", d, vexp(5));
    br(A_CUR_ID, d);  chk("R8 id 5", d, 32'd5);
    bw(A_SET_CMD, 32'h02);
    settle(3); chk("R9 lower blocked", {31'b0, nirq}, 32'd1);
    br(A_IRQ_VEC, d); chk("R11 spurious when blocked", d, 32'h5A5A);
    br(A_CUR_ID, d);  chk("R11 id unchanged", d, 32'd5);
    bw(A_EOI_CMD, 32'h0);
    settle(3);
    br(A_CUR_ID, d); chk("R10 pop to src2", d, 32'd2);
    chk("R10 equal level still blocked", {31'b0, nirq}, 32'd1);
    bw(A_EOI_CMD, 32'h0);
    settle(3);
    br(A_CUR_ID, d); chk("R10 pop to empty", d, 32'd0);
    chk("R10 request re-raised", {31'b0, nirq}, 32'd0);
    br(A_IRQ_VEC, d); chk("R7 vector src1", d, vexp(1));
    bw(A_EOI_CMD, 32'h0);
    bw(A_EOI_CMD, 32'h0);
    br(A_CUR_ID, d); chk("R10 eoi on empty", d, 32'd0);
    settle(3); chk("R10 idle after unwind", {31'b0, nirq}, 32'd1);
    bw(A_SET_CMD, 32'h20);
    settle(3);
    br(A_IRQ_VEC, d); chk("R10 stack usable after empty eoi", d, vexp(5));
    br(A_CUR_ID, d);  chk("R10 id after empty eoi", d, 32'd5);
    bw(A_EOI_CMD, 32'h0);
    bw(A_DIS_CMD, 32'hFF);

    // R8 level source stays pending through acknowledge
    bw(8'd3, 32'h44);
    src[3] = 1'b1;
    bw(A_EN_CMD, 32'h08);
    settle(6); chk("R3 level request", {31'b0, nirq}, 32'd0);
    br(A_IRQ_VEC, d); chk("R7 level vector", d, vexp(3));
    br(A_PENDING, d); chk("R8 level stays pending", 32'(d[3]), 32'd1);
    settle(2); chk("R9 level held by stack", {31'b0, nirq}, 32'd1);
    bw(A_EOI_CMD, 32'h0);
    src[3] = 1'b0;
    settle(6); chk("R3 level released", {31'b0, nirq}, 32'd1);
    br(A_CORE, d); chk("R12 core status idle", d, 32'd3);

    report();
  end
endmodule